// File: doc/BRIEF.md
# Extended Control Register Write Unit

This unit takes one 32-bit instruction word per cycle and carries out two system-control writes. The high-half write copies a 32-bit source operand into bits 63:32 of a control register. The low-half write fills bits 31:0. The control registers sit in a small bank addressed by a register number and a select value. A parameter mask marks some entries as 64 bits wide. All other implemented entries have only a low half, and their upper bits read as zero.

Before a write it runs two checks in a fixed order. The high-half write first checks a feature-enable input, then checks whether the coprocessor is usable. The low-half write checks only usability. A failed check produces a one-cycle exception pulse that carries a cause code, and the bank is left unchanged. Writing the low half of a wide register also clears its upper half. Software must therefore issue the low write first and the high write after it. The surrounding pipeline supplies the source operand, the privilege state and the feature bit. A combinational read port shows both halves of any entry.

Top module: `ctl_reg_hiwr`

## Requirements
- R1: An instruction counts only while `insn_valid` is 1, bits 31:26 are 001000 and bits 2:0 are 000. Bits 9:3 equal to 0001111 select the high-half write, and bits 9:3 equal to 0001110 select the low-half write. Bit 10 is ignored. Any other word has no effect.
- R2: Bits 20:16 give the register number and bits 15:11 the select value. The source operand arrives on `src_val`.
- R3: A high-half write while `feat_hi_en` is 0 raises cause 1 (reserved instruction) and writes nothing. This holds even when the coprocessor is also unusable.
- R4: The coprocessor is usable when `kernel_mode` or `cu0_en` is 1. A write that passes the earlier checks but finds the coprocessor unusable raises cause 2 with `exc_cop` = 0, and writes nothing.
- R5: A high-half write that passes both checks places `src_val` in bits 63:32 of the addressed wide entry and leaves bits 31:0 unchanged.
- R6: A high-half write to an implemented entry without a high half is dropped. It raises no exception and changes no state.
- R7: A low-half write that passes its check loads bits 31:0 and, on a wide entry, clears bits 63:32.
- R8: Entry index = number × NUM_SELS + select. It is valid only when number < NUM_REGS and select < NUM_SELS. Writes outside that range are dropped and reads there return zero.
- R9: `exc_valid` is 1 in the cycle after a failing instruction, for one cycle per such instruction, and 0 otherwise.
- R10: A synchronous active-high reset clears every entry and the exception outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| insn_valid | input | 1 | Instruction word is present |
| insn | input | 32 | Instruction word |
| src_val | input | 32 | Source general register value |
| feat_hi_en | input | 1 | High-half write feature enable |
| kernel_mode | input | 1 | Privileged mode |
| cu0_en | input | 1 | Coprocessor 0 enable |
| rd_num | input | 5 | Read register number |
| rd_sel | input | 5 | Read select value |
| rd_data | output | 64 | Both halves of the read entry |
| exc_valid | output | 1 | Exception pulse |
| exc_cause | output | 2 | 1 reserved instruction, 2 coprocessor unusable |
| exc_cop | output | 2 | Coprocessor number of the fault |

## Verification
A corrupted entry appears on `rd_data` in the first cycle the read port addresses it after the faulty edge. The bench therefore sweeps the read address across written, narrow and unimplemented entries. A wrong check order or a wrong usability term shows up one cycle later as a wrong `exc_cause`, or as a write that should have been blocked. A low-half write that fails to clear the high half stays hidden until that wide entry is read. The bench reads it right after each low write.

// File: rtl/ctl_reg_hiwr.sv
module ctl_reg_hiwr #(
  parameter int NUM_REGS = 4,
  parameter int NUM_SELS = 2,
  parameter logic [NUM_REGS*NUM_SELS-1:0] HI_MASK = 'hA5
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        insn_valid,
  input  logic [31:0] insn,
  input  logic [31:0] src_val,
  input  logic        feat_hi_en,
  input  logic        kernel_mode,
  input  logic        cu0_en,
  input  logic [4:0]  rd_num,
  input  logic [4:0]  rd_sel,
  output logic [63:0] rd_data,
  output logic        exc_valid,
  output logic [1:0]  exc_cause,
  output logic [1:0]  exc_cop
);
  localparam int NENT = NUM_REGS * NUM_SELS;
  localparam int IW = (NENT > 1) ? $clog2(NENT) : 1;
  localparam logic [31:0] OP_MASK = 32'hFC0003FF;
  localparam logic [31:0] HI_PAT  = 32'h20000078;
  localparam logic [31:0] LO_PAT  = 32'h20000070;

  logic [31:0] lo_q [NENT];
  logic [31:0] hi_q [NENT];

  wire [4:0] wr_num = insn[20:16];
  wire [4:0] wr_sel = insn[15:11];
  wire is_hi  = insn_valid && ((insn & OP_MASK) == HI_PAT);
  wire is_lo  = insn_valid && ((insn & OP_MASK) == LO_PAT);
  wire usable = kernel_mode | cu0_en;

  wire raise_ri  = is_hi && !feat_hi_en;
  wire raise_cpu = ((is_hi && feat_hi_en) || is_lo) && !usable;
  wire do_hi = is_hi && feat_hi_en && usable;
  wire do_lo = is_lo && usable;

  wire wr_hit = (32'(wr_num) < NUM_REGS) && (32'(wr_sel) < NUM_SELS);
  wire rd_hit = (32'(rd_num) < NUM_REGS) && (32'(rd_sel) < NUM_SELS);
  wire [IW-1:0] wr_idx = IW'(IW'(wr_num) * IW'(NUM_SELS) + IW'(wr_sel));
  wire [IW-1:0] rd_idx = IW'(IW'(rd_num) * IW'(NUM_SELS) + IW'(rd_sel));

  for (genvar i = 0; i < NENT; i++) begin : g_ent
    wire sel_i = wr_hit && (wr_idx == IW'(i));
    always_ff @(posedge clk) begin
      if (rst) lo_q[i] <= '0;
      else if (do_lo && sel_i) lo_q[i] <= src_val;
    end
    if (HI_MASK[i]) begin : g_wide
      always_ff @(posedge clk) begin
        if (rst) hi_q[i] <= '0;
        else if (do_lo && sel_i) hi_q[i] <= '0;
        else if (do_hi && sel_i) hi_q[i] <= src_val;
      end
    end else begin : g_narrow
      assign hi_q[i] = '0;
    end
  end

  assign rd_data = rd_hit ? {hi_q[rd_idx], lo_q[rd_idx]} : 64'd0;

  always_ff @(posedge clk) begin
    if (rst) begin
      exc_valid <= 1'b0;
      exc_cause <= 2'd0;
    end else begin
      exc_valid <= raise_ri | raise_cpu;
      exc_cause <= raise_ri ? 2'd1 : (raise_cpu ? 2'd2 : 2'd0);
    end
  end

  assign exc_cop = 2'd0;
endmodule

module ctl_reg_hiwr_chk (
  input logic        clk,
  input logic        rst,
  input logic        insn_valid,
  input logic [31:0] insn,
  input logic [31:0] src_val,
  input logic        feat_hi_en,
  input logic        kernel_mode,
  input logic        cu0_en,
  input logic [4:0]  rd_num,
  input logic [4:0]  rd_sel,
  input logic [63:0] rd_data,
  input logic        exc_valid,
  input logic [1:0]  exc_cause,
  input logic [1:0]  exc_cop
);
  wire base  = insn_valid && insn[31:26] == 6'b001000 && insn[2:0] == 3'b000;
  wire hi_op = base && insn[9:3] == 7'b0001111;
  wire lo_op = base && insn[9:3] == 7'b0001110;
  wire ok    = kernel_mode || cu0_en;
  wire unused_ok = ^{src_val, insn[10]};

  assert_ri_cause_R3: assert property (@(posedge clk) disable iff (rst)
    (hi_op && !feat_hi_en) |=> (exc_valid && exc_cause == 2'd1));

  assert_ri_nowrite_R3: assert property (@(posedge clk) disable iff (rst)
    (hi_op && !feat_hi_en) |=> (!$stable(rd_num) || !$stable(rd_sel) || $stable(rd_data)));

  assert_cpu_cause_R4: assert property (@(posedge clk) disable iff (rst)
    (((hi_op && feat_hi_en) || lo_op) && !ok) |=> (exc_valid && exc_cause == 2'd2 && exc_cop == 2'd0));

  assert_pulse_src_R9: assert property (@(posedge clk) disable iff (rst)
    exc_valid |-> ($past(insn_valid) || unused_ok != unused_ok));

  assert_reset_clear_R10: assert property (@(posedge clk)
    rst |=> (rd_data == 64'd0 && !exc_valid));
endmodule

bind ctl_reg_hiwr ctl_reg_hiwr_chk chk_i (.*);

// File: tb/ctl_reg_hiwr_tb_top.sv
module ctl_reg_hiwr_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic insn_valid = 1'b0;
  logic [31:0] insn = '0, src_val = '0;
  logic feat_hi_en = 1'b0, kernel_mode = 1'b0, cu0_en = 1'b0;
  logic [4:0] rd_num = '0, rd_sel = '0;
  logic [63:0] rd_data;
  logic exc_valid;
  logic [1:0] exc_cause, exc_cop;

  int checks = 0, failures = 0;
  logic [31:0] mlo [8];
  logic [31:0] mhi [8];
  localparam logic [7:0] WIDE = 8'b1010_0101;

  always #4 clk = ~clk;

  ctl_reg_hiwr dut_i (.*);

  function automatic logic [31:0] mk(input bit hi, input logic [4:0] rt, num, sel, input bit x);
    return {6'b001000, rt, num, sel, x, (hi ? 7'b0001111 : 7'b0001110), 3'b000};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mread(input int n, s);
    if (n < 4 && s < 2) return {(WIDE[n*2+s] ? mhi[n*2+s] : 32'd0), mlo[n*2+s]};
    return 64'd0;
  endfunction

  task automatic step(input string tag, input logic v, input logic [31:0] w, src,
                      input logic f, k, c, input int rn, rs);
    bit hi, lo, ok, ri, cpu;
    int n, s;
    @(negedge clk);
    insn_valid = v; insn = w; src_val = src; feat_hi_en = f;
    kernel_mode = k; cu0_en = c; rd_num = 5'(rn); rd_sel = 5'(rs);
    hi = v && w[31:26] == 6'b001000 && w[2:0] == 0 && w[9:3] == 7'd15;
    lo = v && w[31:26] == 6'b001000 && w[2:0] == 0 && w[9:3] == 7'd14;
    ok = k || c;
    ri = hi && !f;
    cpu = ((hi && f) || lo) && !ok;
    n = int'(w[20:16]); s = int'(w[15:11]);
    @(posedge clk);
    if (n < 4 && s < 2) begin
      if (lo && ok) begin mlo[n*2+s] = src; mhi[n*2+s] = 0; end
      else if (hi && f && ok && WIDE[n*2+s]) mhi[n*2+s] = src;
    end
    #1;
    chk({tag, " rd"}, rd_data, mread(rn, rs));
    chk({tag, " exc"}, {62'd0, exc_valid}, {63'd0, ri || cpu});
    if (ri || cpu) begin
      chk({tag, " cause"}, {62'd0, exc_cause}, {62'd0, (ri ? 2'd1 : 2'd2)});
      chk({tag, " cop"}, {62'd0, exc_cop}, 64'd0);
    end
  endtask

  initial begin
    #(8 * 200000);
    failures++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin mlo[i] = 0; mhi[i] = 0; end
    repeat (2) @(posedge clk);
    #1 chk("R10 reset rd", rd_data, 64'd0);
    chk("R10 reset exc", {63'd0, exc_valid}, 64'd0);
    @(negedge clk); rst = 1'b0;
    step("R10 idle", 0, 0, 0, 1, 1, 0, 3, 1);
    step("R7 low 0,0", 1, mk(0, 2, 0, 0, 0), 32'h11111111, 1, 1, 0, 0, 0);
    step("R5 R2 high 0,0", 1, mk(1, 3, 0, 0, 0), 32'hAAAA5555, 1, 1, 0, 0, 0);
    step("R1 bit10 high 2,1", 1, mk(1, 4, 2, 1, 1), 32'hCAFEF00D, 1, 0, 1, 2, 1);
    step("R3 feat off", 1, mk(1, 1, 0, 0, 0), 32'hDEADBEEF, 0, 1, 1, 0, 0);
    step("R3 feat off unusable", 1, mk(1, 1, 0, 0, 0), 32'h12345678, 0, 0, 0, 0, 0);
    step("R9 after exc", 0, 0, 0, 1, 1, 1, 0, 0);
    step("R4 high unusable", 1, mk(1, 1, 2, 0, 0), 32'h0BAD0BAD, 1, 0, 0, 2, 0);
    step("R4 low unusable", 1, mk(0, 1, 2, 0, 0), 32'h0BAD0BAD, 1, 0, 0, 2, 0);
    step("R4 cu0 usable", 1, mk(1, 1, 2, 0, 0), 32'h77778888, 1, 0, 1, 2, 0);
    step("R6 narrow high", 1, mk(1, 1, 0, 1, 0), 32'h99999999, 1, 1, 1, 0, 1);
    step("R6 narrow low", 1, mk(0, 1, 0, 1, 0), 32'h13572468, 1, 1, 1, 0, 1);
    step("R7 low clears high", 1, mk(0, 1, 0, 0, 0), 32'h22222222, 1, 1, 0, 0, 0);
    step("R8 num out", 1, mk(0, 1, 5, 0, 0), 32'h55555555, 1, 1, 0, 5, 0);
    step("R8 sel out", 1, mk(1, 1, 1, 3, 0), 32'h66666666, 1, 1, 0, 1, 3);
    step("R1 bad op", 1, {6'b001001, mk(1, 1, 3, 1, 0)}[31:0] ^ 32'h04000000, 32'h1, 1, 1, 0, 3, 1);
    step("R1 bad low bits", 1, mk(1, 1, 3, 1, 0) | 32'h1, 32'h2, 1, 1, 0, 3, 1);
    step("R1 not valid", 0, mk(0, 1, 3, 1, 0), 32'h3, 1, 1, 0, 3, 1);
    step("R5 high 3,1", 1, mk(1, 1, 3, 1, 0), 32'hFEEDFACE, 1, 1, 0, 3, 1);
    step("R9 back to back a", 1, mk(0, 1, 1, 0, 0), 32'h4, 0, 0, 0, 0, 0);
    step("R9 back to back b", 1, mk(1, 1, 1, 0, 0), 32'h5, 0, 1, 0, 2, 1);
    step("R9 quiet", 0, 0, 0, 1, 1, 0, 2, 1);
    for (int a = 0; a < 8; a++) step("R2 sweep", 0, 0, 0, 1, 1, 0, a / 2, a % 2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule